// File: doc/BRIEF.md
# BCD Calendar Counter with Carry Flag

This block is the timekeeping core of a real-time clock. It keeps seconds, minutes, hours, weekday, day of month, month and a four-digit year as packed BCD counters. A binary sub-second counter counts pulses on a 128 Hz tick input and sits in front of them. Every field is reached through a small synchronous register port: word-indexed address, write strobe, write data and a combinational read path.

Software stops counting, loads the time and then restarts counting. A control write can clear the sub-second prescaler at the same time. A multi-field read can be split by a seconds rollover. To catch this, a sticky carry flag is set on every seconds advance. Software clears the flag, reads all fields, and reads again if the flag came back. The flag can also raise an interrupt request when its enable bit is set.

Top module: `rtc_calendar_core`

## Requirements
- R1: After a synchronous active-low reset the sub-second counter, seconds, minutes, hours and weekday read 0, day and month read 0x01, the year reads 0x2000, both control registers read 0x0000 and the interrupt request is low.
- R2: Register index 0 is the sub-second counter (read only), 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 day, 6 month, 7 year (16 bits, BCD century in bits 15:8 and BCD year in bits 7:0), 14 control 1 and 15 control 2. Indices 8 to 13 read as zero and writes to them change nothing. Reads are combinational.
- R3: Counting runs only while control 2 bit 3 (enable) and bit 0 (start) are both 1. Otherwise tick pulses are ignored and every counter holds.
- R4: While running, each tick pulse increments the sub-second counter. Its wrap from 127 to 0 advances the seconds by one.
- R5: Seconds and minutes wrap from 0x59 to 0x00, and each wrap carries into the next field. Hours wrap from 0x23 to 0x00 and advance both the day and the weekday. The weekday wraps from 0x06 to 0x00.
- R6: The day wraps to 0x01 after the last day of the month and advances the month. Months 4, 6, 9 and 11 have 30 days. February has 29 days when the BCD year byte is divisible by 4 (00 included) and 28 days otherwise. All other months have 31 days.
- R7: Month 0x12 wraps to 0x01 and advances the year byte. Year byte 0x99 wraps to 0x00 and advances the century byte.
- R8: A write to a counter register (indices 1 to 7) is visible on the clock after the write. If the same field would advance in that cycle, the written value wins.
- R9: A write to control 2 with bit 1 set clears the sub-second counter on the next clock. Bit 1 always reads 0.
- R10: Control 1 bit 7 is the carry flag. It is set on every seconds advance. A write of 0 to it clears it and a write of 1 leaves it unchanged. When a seconds advance and a clearing write fall in the same cycle, the flag ends up set.
- R11: Control 1 bit 4 is the carry interrupt enable. The interrupt request output is high exactly while the carry flag and this enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | 128 Hz tick, one clock wide per pulse |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word index |
| wr_data_i | input | 16 | Register write data |
| rd_data_o | output | 16 | Read data for addr_i (combinational) |
| carry_irq_o | output | 1 | Carry interrupt request |

## Verification
The bench builds the block with its default parameters: a 7-bit sub-second counter and a reset year of 2000. With these values one simulated second takes 128 tick pulses, so every cascade is reached within a few hundred cycles: a minute, hour, month-end, February in leap and common years, and the century rollover. The 127-to-0 boundary is also used to line up a tick exactly with a register write. This tests the cases where a write meets an advance: the flag-set-versus-clear race and the write-wins override.

// File: rtl/rtc_cal_pkg.sv
// Package rtc_cal_pkg
// Shared constants and pure functions for the calendar core: register
// indices, control bit positions, BCD increment and month-length logic.
// Assumes all calendar bytes hold valid packed BCD.
package rtc_cal_pkg;

    localparam int DATA_W     = 16;
    localparam int ADDR_W     = 4;
    localparam int NUM_FIELDS = 8;

    // field slots in the counter chain
    localparam int FLD_SEC  = 0;
    localparam int FLD_MIN  = 1;
    localparam int FLD_HOUR = 2;
    localparam int FLD_WDAY = 3;
    localparam int FLD_DAY  = 4;
    localparam int FLD_MON  = 5;
    localparam int FLD_YLO  = 6;
    localparam int FLD_YHI  = 7;

    // register word indices (ordering is decoded by software)
    localparam logic [ADDR_W-1:0] IDX_SUBSEC = 4'd0;
    localparam logic [ADDR_W-1:0] IDX_YEAR   = 4'd7;
    localparam logic [ADDR_W-1:0] IDX_CTRL1  = 4'd14;
    localparam logic [ADDR_W-1:0] IDX_CTRL2  = 4'd15;

    // control bit positions
    localparam int C1_CARRY = 7;
    localparam int C1_CIE   = 4;
    localparam int C2_EN    = 3;
    localparam int C2_PCLR  = 1;
    localparam int C2_START = 0;

    // add one to a two-digit BCD byte
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    // BCD year byte divisible by four
    function automatic logic bcd_leap(input logic [7:0] y);
        logic r;
        if (y[4]) r = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        else      r = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
        return r;
    endfunction

    // last BCD day of a BCD month
    function automatic logic [7:0] month_last_day(input logic [7:0] mon,
                                                  input logic       leap);
        logic [7:0] r;
        case (mon)
            8'h02:                      r = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
            default:                    r = 8'h31;
        endcase
        return r;
    endfunction

    // lowest value a field wraps to
    function automatic logic [7:0] field_floor(input int f);
        return (f == FLD_DAY || f == FLD_MON) ? 8'h01 : 8'h00;
    endfunction

    // fixed top value of a field (day uses a dynamic limit)
    function automatic logic [7:0] field_top(input int f);
        logic [7:0] r;
        case (f)
            FLD_SEC, FLD_MIN: r = 8'h59;
            FLD_HOUR:         r = 8'h23;
            FLD_WDAY:         r = 8'h06;
            FLD_MON:          r = 8'h12;
            default:          r = 8'h99;
        endcase
        return r;
    endfunction

    // value after reset
    function automatic logic [7:0] field_init(input int f,
                                              input logic [7:0] century,
                                              input logic [7:0] year);
        logic [7:0] r;
        case (f)
            FLD_YHI: r = century;
            FLD_YLO: r = year;
            default: r = field_floor(f);
        endcase
        return r;
    endfunction

    // bit of the wrap vector that advances field f (bit 0 = sub-second)
    function automatic int field_parent(input int f);
        return (f == FLD_DAY) ? FLD_WDAY : f;
    endfunction

endpackage

// File: rtl/rtc_bcd_field.sv
// Module rtc_bcd_field
// One packed-BCD calendar counter. Advances by one on adv_i and wraps to
// FLOOR once at or above top_i, raising wrap_o in that cycle. A load
// overrides an advance. Assumes top_i is valid BCD and at least FLOOR.
module rtc_bcd_field #(
    parameter logic [7:0] FLOOR = 8'h00,
    parameter logic [7:0] INIT  = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv_i,
    input  logic       load_i,
    input  logic [7:0] load_val_i,
    input  logic [7:0] top_i,
    output logic [7:0] val_o,
    output logic       wrap_o
);
    import rtc_cal_pkg::*;

    logic [7:0] val_q;
    logic       at_top;

    // detect the end of the range (>= tolerates out-of-range loads)
    always_comb at_top = (val_q >= top_i);

    // counter register: reset, load, advance with wrap
    always_ff @(posedge clk) begin
        if (!rst_n)      val_q <= INIT;
        else if (load_i) val_q <= load_val_i;
        else if (adv_i)  val_q <= at_top ? FLOOR : bcd_inc(val_q);
    end

    // carry out to the next field
    always_comb wrap_o = adv_i && !load_i && at_top;

    assign val_o = val_q;

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !load_i) |=> $stable(val_q));

    p_wrap_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (val_q == FLOOR));

    p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (val_q == $past(load_val_i)));

endmodule

// File: rtl/rtc_subsec_counter.sv
// Module rtc_subsec_counter
// Free-running binary prescaler of the 128 Hz tick. A clear request wins
// over a tick. wrap_o marks the all-ones to zero step that feeds seconds.
module rtc_subsec_counter #(
    parameter int WIDTH = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             adv_i,
    output logic [WIDTH-1:0] count_o,
    output logic             wrap_o
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    logic [WIDTH-1:0] cnt_q;

    // prescaler register: reset, clear, count
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clear_i) cnt_q <= '0;
        else if (adv_i)   cnt_q <= cnt_q + 1'b1;
    end

    // seconds strobe on the wrapping tick
    always_comb wrap_o = adv_i && !clear_i && (cnt_q == ALL_ONES);

    assign count_o = cnt_q;

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_q == '0));

    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !clear_i) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/rtc_ctrl_regs.sv
// Module rtc_ctrl_regs
// The two control registers: enable, start, carry interrupt enable, the
// sticky carry flag and the prescaler clear strobe. A carry set wins over
// a same-cycle clearing write.
module rtc_ctrl_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic wr1_i,
    input  logic wr2_i,
    input  logic carry_wval_i,
    input  logic cie_wval_i,
    input  logic en_wval_i,
    input  logic pclr_wval_i,
    input  logic start_wval_i,
    input  logic carry_set_i,
    output logic carry_o,
    output logic cie_o,
    output logic en_o,
    output logic start_o,
    output logic run_o,
    output logic pclr_o,
    output logic irq_o
);
    logic carry_q, cie_q, en_q, start_q;

    // control 1: carry flag (write 0 clears, set wins) and its enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
            cie_q   <= 1'b0;
        end else begin
            if (carry_set_i)                carry_q <= 1'b1;
            else if (wr1_i && !carry_wval_i) carry_q <= 1'b0;
            if (wr1_i) cie_q <= cie_wval_i;
        end
    end

    // control 2: enable and start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            start_q <= 1'b0;
        end else if (wr2_i) begin
            en_q    <= en_wval_i;
            start_q <= start_wval_i;
        end
    end

    // outputs: running state, prescaler clear strobe, interrupt
    always_comb begin
        run_o  = en_q && start_q;
        pclr_o = wr2_i && pclr_wval_i;
        irq_o  = carry_q && cie_q;
    end

    assign carry_o = carry_q;
    assign cie_o   = cie_q;
    assign en_o    = en_q;
    assign start_o = start_q;

    p_carry_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        carry_set_i |=> carry_q);

    p_carry_write1_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr1_i && carry_wval_i && carry_q) |=> carry_q);

    p_irq_needs_enable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr1_i && !cie_wval_i) |=> !irq_o);

endmodule

// File: rtl/rtc_calendar_core.sv
// Module rtc_calendar_core
// Real-time clock core: 128 Hz prescaler, BCD seconds to century chain,
// register port and carry interrupt. Assumes tick_i pulses last one clock
// and that software loads valid BCD values.
module rtc_calendar_core #(
    parameter int         SUBSEC_W     = 7,
    parameter logic [7:0] INIT_CENTURY = 8'h20,
    parameter logic [7:0] INIT_YEAR    = 8'h00
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            tick_i,
    input  logic                            wr_en_i,
    input  logic [rtc_cal_pkg::ADDR_W-1:0]  addr_i,
    input  logic [rtc_cal_pkg::DATA_W-1:0]  wr_data_i,
    output logic [rtc_cal_pkg::DATA_W-1:0]  rd_data_o,
    output logic                            carry_irq_o
);
    import rtc_cal_pkg::*;

    localparam int PAD_W = DATA_W - SUBSEC_W;

    logic [SUBSEC_W-1:0] subsec;
    logic                sub_wrap;
    logic                run, pclr;
    logic                carry, cie, en, start;
    logic                wr1, wr2;
    logic [NUM_FIELDS:0] wraps;
    logic [7:0]          fval   [NUM_FIELDS];
    logic [7:0]          ftop   [NUM_FIELDS];
    logic [7:0]          fload_v[NUM_FIELDS];
    logic [NUM_FIELDS-1:0] fload;
    logic [7:0]          day_top;

    // control register write strobes
    always_comb begin
        wr1 = wr_en_i && (addr_i == IDX_CTRL1);
        wr2 = wr_en_i && (addr_i == IDX_CTRL2);
    end

    rtc_ctrl_regs u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr1_i        (wr1),
        .wr2_i        (wr2),
        .carry_wval_i (wr_data_i[C1_CARRY]),
        .cie_wval_i   (wr_data_i[C1_CIE]),
        .en_wval_i    (wr_data_i[C2_EN]),
        .pclr_wval_i  (wr_data_i[C2_PCLR]),
        .start_wval_i (wr_data_i[C2_START]),
        .carry_set_i  (sub_wrap),
        .carry_o      (carry),
        .cie_o        (cie),
        .en_o         (en),
        .start_o      (start),
        .run_o        (run),
        .pclr_o       (pclr),
        .irq_o        (carry_irq_o)
    );

    rtc_subsec_counter #(.WIDTH(SUBSEC_W)) u_subsec (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (pclr),
        .adv_i   (tick_i && run),
        .count_o (subsec),
        .wrap_o  (sub_wrap)
    );

    // month length from the current month and year byte
    always_comb day_top = month_last_day(fval[FLD_MON], bcd_leap(fval[FLD_YLO]));

    assign wraps[0] = sub_wrap;

    // one BCD counter per calendar byte, chained through the wrap vector
    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        localparam logic [ADDR_W-1:0] FIDX =
            (f >= FLD_YLO) ? IDX_YEAR : ADDR_W'(f + 1);

        // load strobe and value for this byte
        always_comb begin
            fload[f]   = wr_en_i && (addr_i == FIDX);
            fload_v[f] = (f == FLD_YHI) ? wr_data_i[15:8] : wr_data_i[7:0];
            ftop[f]    = (f == FLD_DAY) ? day_top : field_top(f);
        end

        rtc_bcd_field #(
            .FLOOR (field_floor(f)),
            .INIT  (field_init(f, INIT_CENTURY, INIT_YEAR))
        ) u_fld (
            .clk        (clk),
            .rst_n      (rst_n),
            .adv_i      (wraps[field_parent(f)]),
            .load_i     (fload[f]),
            .load_val_i (fload_v[f]),
            .top_i      (ftop[f]),
            .val_o      (fval[f]),
            .wrap_o     (wraps[f+1])
        );
    end

    // combinational read mux
    always_comb begin
        rd_data_o = '0;
        case (addr_i)
            IDX_SUBSEC: rd_data_o = {{PAD_W{1'b0}}, subsec};
            4'd1:       rd_data_o = {8'h00, fval[FLD_SEC]};
            4'd2:       rd_data_o = {8'h00, fval[FLD_MIN]};
            4'd3:       rd_data_o = {8'h00, fval[FLD_HOUR]};
            4'd4:       rd_data_o = {8'h00, fval[FLD_WDAY]};
            4'd5:       rd_data_o = {8'h00, fval[FLD_DAY]};
            4'd6:       rd_data_o = {8'h00, fval[FLD_MON]};
            IDX_YEAR:   rd_data_o = {fval[FLD_YHI], fval[FLD_YLO]};
            IDX_CTRL1:  rd_data_o = {8'h00, carry, 2'b00, cie, 4'b0000};
            IDX_CTRL2:  rd_data_o = {8'h00, 4'b0000, en, 2'b00, start};
            default:    rd_data_o = '0;
        endcase
    end

    p_stopped_prescaler_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !pclr) |=> $stable(subsec));

    p_sec_follows_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_wrap && !fload[FLD_SEC]) |=> (fval[FLD_SEC] != $past(fval[FLD_SEC])));

    p_day_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wraps[FLD_DAY+1]) |=> (fval[FLD_DAY] == 8'h01));

endmodule

// File: tb/rtc_calendar_core_bench.sv
module rtc_calendar_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [3:0]  addr_i = '0;
    logic [15:0] wr_data_i = '0;
    logic [15:0] rd_data_o;
    logic        carry_irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    rtc_calendar_core u_rtc_calendar_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .wr_en_i     (wr_en_i),
        .addr_i      (addr_i),
        .wr_data_i   (wr_data_i),
        .rd_data_o   (rd_data_o),
        .carry_irq_o (carry_irq_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [15:0] exp);
        addr_i = a;
        #1;
        check(req, rd_data_o, exp);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_i = 1'b1;
            @(negedge clk); tick_i = 1'b0;
        end
    endtask

    // tick and register write in the same cycle
    task automatic tick_with_write(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        tick_i = 1'b1; wr_en_i = 1'b1; addr_i = a; wr_data_i = d;
        @(negedge clk);
        tick_i = 1'b0; wr_en_i = 1'b0;
    endtask

    task automatic t_reset;
        rd_chk("R1 subsec", 4'd0, 16'h0000);
        rd_chk("R1 sec", 4'd1, 16'h0000);
        rd_chk("R1 min", 4'd2, 16'h0000);
        rd_chk("R1 hour", 4'd3, 16'h0000);
        rd_chk("R1 wday", 4'd4, 16'h0000);
        rd_chk("R1 day", 4'd5, 16'h0001);
        rd_chk("R1 month", 4'd6, 16'h0001);
        rd_chk("R1 year", 4'd7, 16'h2000);
        rd_chk("R1 ctrl1", 4'd14, 16'h0000);
        rd_chk("R1 ctrl2", 4'd15, 16'h0000);
        check("R1 irq", {15'd0, carry_irq_o}, 16'h0000);
    endtask

    task automatic t_frozen;
        ticks(10);
        rd_chk("R3 stopped", 4'd0, 16'h0000);
        wr(4'd15, 16'h0001);
        ticks(10);
        rd_chk("R3 start only", 4'd0, 16'h0000);
        wr(4'd15, 16'h0008);
        ticks(10);
        rd_chk("R3 enable only", 4'd0, 16'h0000);
        rd_chk("R3 sec held", 4'd1, 16'h0000);
        rd_chk("R3 ctrl2 readback", 4'd15, 16'h0008);
    endtask

    task automatic t_subsec;
        wr(4'd15, 16'h0009);
        ticks(5);
        rd_chk("R4 subsec five", 4'd0, 16'h0005);
        wr(4'd15, 16'h000B);
        rd_chk("R9 prescaler cleared", 4'd0, 16'h0000);
        rd_chk("R9 clear bit reads 0", 4'd15, 16'h0009);
        ticks(127);
        rd_chk("R4 subsec 127", 4'd0, 16'h007F);
        rd_chk("R4 sec not yet", 4'd1, 16'h0000);
        rd_chk("R10 flag not yet", 4'd14, 16'h0000);
        ticks(1);
        rd_chk("R4 subsec wrapped", 4'd0, 16'h0000);
        rd_chk("R4 sec advanced", 4'd1, 16'h0001);
        rd_chk("R10 flag set", 4'd14, 16'h0080);
    endtask

    task automatic t_carry;
        check("R11 irq off without enable", {15'd0, carry_irq_o}, 16'h0000);
        wr(4'd14, 16'h0080);
        rd_chk("R10 write 1 keeps flag", 4'd14, 16'h0080);
        wr(4'd14, 16'h0010);
        rd_chk("R10 write 0 clears", 4'd14, 16'h0010);
        check("R11 irq low flag clear", {15'd0, carry_irq_o}, 16'h0000);
        ticks(128);
        rd_chk("R10 flag again", 4'd14, 16'h0090);
        check("R11 irq high", {15'd0, carry_irq_o}, 16'h0001);
        wr(4'd14, 16'h0090);
        check("R11 irq stays", {15'd0, carry_irq_o}, 16'h0001);
        wr(4'd14, 16'h0000);
        check("R11 irq drops", {15'd0, carry_irq_o}, 16'h0000);
    endtask

    task automatic t_race;
        ticks(127);
        tick_with_write(4'd14, 16'h0000);
        rd_chk("R10 set wins over clear", 4'd14, 16'h0080);
        ticks(127);
        tick_with_write(4'd1, 16'h0033);
        rd_chk("R8 write wins over advance", 4'd1, 16'h0033);
        rd_chk("R4 subsec wrapped in race", 4'd0, 16'h0000);
    endtask

    task automatic t_map;
        for (int a = 8; a < 14; a++) wr(4'(a), 16'hFFFF);
        for (int a = 8; a < 14; a++) rd_chk("R2 reserved reads 0", 4'(a), 16'h0000);
        rd_chk("R2 sec untouched", 4'd1, 16'h0033);
        rd_chk("R2 ctrl1 untouched", 4'd14, 16'h0080);
        wr(4'd0, 16'h0055);
        rd_chk("R2 subsec read only", 4'd0, 16'h0000);
    endtask

    task automatic set_time(input logic [15:0] y, input logic [7:0] mo, input logic [7:0] d,
                            input logic [7:0] wd, input logic [7:0] h, input logic [7:0] mi,
                            input logic [7:0] s);
        wr(4'd15, 16'h0000);
        wr(4'd1, {8'h00, s});
        rd_chk("R8 load visible next clock", 4'd1, {8'h00, s});
        wr(4'd2, {8'h00, mi});
        wr(4'd3, {8'h00, h});
        wr(4'd4, {8'h00, wd});
        wr(4'd5, {8'h00, d});
        wr(4'd6, {8'h00, mo});
        wr(4'd7, y);
        wr(4'd15, 16'h000B);
    endtask

    task automatic expect_time(input string req, input logic [15:0] y, input logic [7:0] mo,
                               input logic [7:0] d, input logic [7:0] wd, input logic [7:0] h,
                               input logic [7:0] mi, input logic [7:0] s);
        rd_chk(req, 4'd1, {8'h00, s});
        rd_chk(req, 4'd2, {8'h00, mi});
        rd_chk(req, 4'd3, {8'h00, h});
        rd_chk(req, 4'd4, {8'h00, wd});
        rd_chk(req, 4'd5, {8'h00, d});
        rd_chk(req, 4'd6, {8'h00, mo});
        rd_chk(req, 4'd7, y);
    endtask

    task automatic t_rollovers;
        set_time(16'h2023, 8'h06, 8'h15, 8'h02, 8'h10, 8'h59, 8'h59);
        ticks(128);
        expect_time("R5 hour carry", 16'h2023, 8'h06, 8'h15, 8'h02, 8'h11, 8'h00, 8'h00);
        set_time(16'h2023, 8'h04, 8'h30, 8'h00, 8'h23, 8'h59, 8'h59);
        ticks(128);
        expect_time("R6 thirty-day month", 16'h2023, 8'h05, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
        set_time(16'h2024, 8'h02, 8'h28, 8'h06, 8'h23, 8'h59, 8'h59);
        ticks(128);
        expect_time("R6 leap Feb 29 and R5 wday wrap", 16'h2024, 8'h02, 8'h29, 8'h00, 8'h00, 8'h00, 8'h00);
        set_time(16'h2023, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
        ticks(128);
        expect_time("R6 common Feb end", 16'h2023, 8'h03, 8'h01, 8'h04, 8'h00, 8'h00, 8'h00);
        set_time(16'h2024, 8'h02, 8'h29, 8'h04, 8'h23, 8'h59, 8'h59);
        ticks(128);
        expect_time("R6 leap Feb end", 16'h2024, 8'h03, 8'h01, 8'h05, 8'h00, 8'h00, 8'h00);
        set_time(16'h2000, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
        ticks(128);
        expect_time("R6 year 00 leap", 16'h2000, 8'h02, 8'h29, 8'h02, 8'h00, 8'h00, 8'h00);
        set_time(16'h2024, 8'h01, 8'h31, 8'h02, 8'h23, 8'h59, 8'h59);
        ticks(128);
        expect_time("R6 thirty-one day month", 16'h2024, 8'h02, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00);
        set_time(16'h2099, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
        ticks(128);
        expect_time("R7 century rollover", 16'h2100, 8'h01, 8'h01, 8'h06, 8'h00, 8'h00, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_frozen();
        t_subsec();
        t_carry();
        t_race();
        t_map();
        t_rollovers();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule